// File: doc/BRIEF.md
# Byte-FIFO SPI Master with Framed Select

This block is an SPI master that moves whole bytes between a 16-entry transmit FIFO and a 16-entry receive FIFO. Software queues bytes through a write port. A shift engine clocks each byte out on MOSI and samples MISO into the receive FIFO at the same time. Clock polarity, clock phase, bit order and a 16-bit edge divider are taken from configuration registers.

Hardware drives the active-low slave select. When framing is off, select is released after every byte. When framing is on, select stays low across consecutive bytes. It is released only after a byte that software tagged as frame end has finished shifting. The tag is a ninth bit stored in the transmit FIFO next to the byte. It is armed by a command bit before the data write.

A transmit-idle status bit is set once the transmit FIFO has drained and the last byte has finished. The interrupt line is the AND of that status bit and a mask bit, and the status bit is cleared by writing a one to it.

Register word addresses on `reg_addr_i`:

| Address | Access | Contents |
|---|---|---|
| 0 | read/write | mode register |
| 1 | read/write | divider register |
| 2 | write | command bits |
| 2 | read | {mark, rx enable, tx enable} in bits 2:0 |
| 3 | write | transmit data |
| 4 | read | receive data |
| 5 | read | level and flag register |
| 6 | read, write-one-to-clear | status register |
| 7 | read/write | mask register |

Command bits at address 2:

| Bit | Effect |
|---|---|
| 0 | reset receiver |
| 1 | reset transmitter |
| 2 | rx on |
| 3 | rx off |
| 4 | tx on |
| 5 | tx off |
| 6 | arm frame-end mark |

When an on bit and its matching off bit are written together, off wins.

Top module: `spi_eof_master`

## Requirements
- R1: After reset, ss_n_o is 1, sck_o is 0 and irq_o is 0. The level register (address 5) reads 0, the command readback reads 0, and transmitter and receiver are disabled.
- R2: Mode register bit 13 selects the idle SCK level (polarity). Bit 12 selects the phase. With phase 0, MOSI is valid before the first edge and data is sampled on leading edges. With phase 1, data is sampled on trailing edges. SCK sits at the polarity level whenever no byte is in flight.
- R3: Mode register bit 28 set to 1 shifts bytes LSB first, and set to 0 shifts them MSB first. The same order is used on MOSI and MISO.
- R4: The divider is {reg1[15:8], reg1[23:16]}. While shifting, SCK changes level every divider+1 clock cycles. Bits 31:24 of register 1 are stored and read back unchanged.
- R5: Each byte shifted pushes one byte sampled from miso_i into the receive FIFO. A read of address 4 returns the oldest byte and pops it. Address 5 holds the receive count in bits 7:0 and the transmit count in bits 15:8.
- R6: With mode bit 11 set, ss_n_o stays low between bytes until a byte written after command bit 6 has finished. It then rises divider+1 cycles after the last SCK edge. With bit 11 clear, ss_n_o rises after every byte.
- R7: While the transmitter is disabled (command bit 5), no SCK edge occurs and queued bytes stay in the FIFO. Command bit 4 restarts shifting.
- R8: While the receiver is disabled (command bit 3), received bytes are discarded. The receive count stays unchanged.
- R9: A transmit write to a full FIFO (16 bytes) is dropped and sets the sticky overflow flag, address 5 bit 16. Command bit 1 flushes the transmit FIFO and clears the flag.
- R10: A received byte arriving at a full receive FIFO is dropped and sets the sticky overrun flag, address 5 bit 17. Command bit 0 flushes the receive FIFO and clears the flag.
- R11: Status bit 0 at address 6 is set when the transmit FIFO becomes empty with no byte in flight. Writing 1 to it clears it, and writing 0 leaves it unchanged. irq_o equals status bit 0 AND mask bit 0 at address 7.
- R12: FIFO counts never exceed the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| reg_we_i | input | 1 | register write strobe |
| reg_re_i | input | 1 | register read strobe (pops receive data at address 4) |
| reg_addr_i | input | 3 | register word address |
| reg_wdata_i | input | 32 | write data |
| reg_rdata_o | output | 32 | read data, combinational from the address |
| irq_o | output | 1 | transmit-idle interrupt |
| sck_o | output | 1 | serial clock |
| mosi_o | output | 1 | serial data out |
| miso_i | input | 1 | serial data in |
| ss_n_o | output | 1 | slave select, active low |

## Verification
The checks assume that the mode register is not rewritten while a byte is in flight. They also assume that each register access is a single-cycle strobe with only one access per cycle. The stimulus keeps to this by waiting on the transmit-idle status bit before it changes the mode or the divider. MISO is looped back from MOSI, so it only changes on the engine's own drive edges. Bytes are fed in bursts of at most 16, so the deliberate overflow case is the only one that overfills the FIFO.

// File: rtl/spi_eof_pkg.sv
package spi_eof_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned DIV_W  = 16;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMD   = 3'd2;
  localparam logic [ADDR_W-1:0] A_TXD   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RXD   = 3'd4;
  localparam logic [ADDR_W-1:0] A_LEVEL = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd6;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd7;

  localparam int unsigned M_FRAME = 11;
  localparam int unsigned M_CPHA  = 12;
  localparam int unsigned M_CPOL  = 13;
  localparam int unsigned M_LSB   = 28;

  localparam int unsigned C_RX_RST = 0;
  localparam int unsigned C_TX_RST = 1;
  localparam int unsigned C_RX_ON  = 2;
  localparam int unsigned C_RX_OFF = 3;
  localparam int unsigned C_TX_ON  = 4;
  localparam int unsigned C_TX_OFF = 5;
  localparam int unsigned C_MARK   = 6;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SHIFT,
    ENG_GAP
  } eng_state_e;
endpackage

// File: rtl/spi_eof_fifo.sv
module spi_eof_fifo #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign data_o  = mem_q[rd_ptr_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= bump(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_ptr_q] <= data_i;
  end
endmodule

// File: rtl/spi_eof_tick.sv
module spi_eof_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_eof_engine.sv
module spi_eof_engine
  import spi_eof_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned DIVW = 16,
  localparam int unsigned EDGES = 2 * DW,
  localparam int unsigned IDX_W = $clog2(EDGES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            abort_i,
  input  logic            tx_en_i,
  input  logic            cpol_i,
  input  logic            cpha_i,
  input  logic            lsb_i,
  input  logic            frame_en_i,
  input  logic [DIVW-1:0] div_i,
  input  logic            fifo_empty_i,
  input  logic [DW:0]     fifo_data_i,
  output logic            fifo_pop_o,
  output logic            rx_push_o,
  output logic [DW-1:0]   rx_data_o,
  output logic            busy_o,
  output logic            sck_o,
  output logic            mosi_o,
  output logic            ss_n_o,
  input  logic            miso_i
);
  eng_state_e       state_q;
  logic [DW-1:0]    tx_sh_q, rx_sh_q, rx_next;
  logic [IDX_W-1:0] idx_q;
  logic             tag_q, sck_q, mosi_q, ss_n_q;
  logic             tick, start, edge_ev, leading, last, sample, drive;

  function automatic logic out_bit(input logic [DW-1:0] v, input logic lsb);
    return lsb ? v[0] : v[DW-1];
  endfunction

  function automatic logic [DW-1:0] shift_out(input logic [DW-1:0] v, input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] v, input logic b,
                                             input logic lsb);
    return lsb ? {b, v[DW-1:1]} : {v[DW-2:0], b};
  endfunction

  spi_eof_tick #(.DIV_W(DIVW)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  ((state_q != ENG_IDLE) && tx_en_i),
    .div_i  (div_i),
    .tick_o (tick)
  );

  assign start   = (state_q == ENG_IDLE) && tx_en_i && !fifo_empty_i && !abort_i;
  assign edge_ev = tick && (state_q == ENG_SHIFT);
  assign leading = !idx_q[0];
  assign last    = (idx_q == IDX_W'(EDGES - 1));
  assign sample  = edge_ev && (cpha_i ? !leading : leading);
  assign drive   = edge_ev && (cpha_i ? leading : (!leading && !last));
  assign rx_next = sample ? shift_in(rx_sh_q, miso_i, lsb_i) : rx_sh_q;

  assign fifo_pop_o = start;
  assign rx_push_o  = edge_ev && last;
  assign rx_data_o  = rx_next;
  assign busy_o     = (state_q != ENG_IDLE);
  assign sck_o      = sck_q ^ cpol_i;
  assign mosi_o     = mosi_q;
  assign ss_n_o     = ss_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      idx_q   <= '0;
      tag_q   <= 1'b0;
      sck_q   <= 1'b0;
      mosi_q  <= 1'b0;
      ss_n_q  <= 1'b1;
    end else if (abort_i) begin
      state_q <= ENG_IDLE;
      sck_q   <= 1'b0;
      ss_n_q  <= 1'b1;
    end else begin
      unique case (state_q)
        ENG_IDLE: begin
          if (start) begin
            tag_q   <= fifo_data_i[DW];
            rx_sh_q <= '0;
            idx_q   <= '0;
            ss_n_q  <= 1'b0;
            state_q <= ENG_SHIFT;
            if (cpha_i) begin
              tx_sh_q <= fifo_data_i[DW-1:0];
            end else begin
              mosi_q  <= out_bit(fifo_data_i[DW-1:0], lsb_i);
              tx_sh_q <= shift_out(fifo_data_i[DW-1:0], lsb_i);
            end
          end
        end
        ENG_SHIFT: begin
          if (edge_ev) begin
            sck_q   <= !sck_q;
            idx_q   <= idx_q + 1'b1;
            rx_sh_q <= rx_next;
            if (drive) begin
              mosi_q  <= out_bit(tx_sh_q, lsb_i);
              tx_sh_q <= shift_out(tx_sh_q, lsb_i);
            end
            if (last) state_q <= ENG_GAP;
          end
        end
        ENG_GAP: begin
          if (tick) begin
            if (!frame_en_i || tag_q) ss_n_q <= 1'b1;
            state_q <= ENG_IDLE;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_eof_master.sv
module spi_eof_master
  import spi_eof_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              ss_n_o
);
  logic [REG_W-1:0]  mode_q, div_reg_q;
  logic              tx_en_q, rx_en_q, mark_q, ovf_q, ovr_q, stat_q, mask_q, tx_idle_q;
  logic              wr_cmd, tx_rst, rx_rst, tx_wr, rx_rd, tx_idle;
  logic              tx_full, tx_empty, rx_full, rx_empty, tx_pop, eng_push, rx_push, eng_busy;
  logic [DATA_W:0]   tx_head;
  logic [DATA_W-1:0] rx_head, eng_rx;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic [DIV_W-1:0]  div;

  assign div     = {div_reg_q[15:8], div_reg_q[23:16]};
  assign wr_cmd  = reg_we_i && (reg_addr_i == A_CMD);
  assign tx_rst  = wr_cmd && reg_wdata_i[C_TX_RST];
  assign rx_rst  = wr_cmd && reg_wdata_i[C_RX_RST];
  assign tx_wr   = reg_we_i && (reg_addr_i == A_TXD);
  assign rx_rd   = reg_re_i && (reg_addr_i == A_RXD);
  assign rx_push = eng_push && rx_en_q;
  assign tx_idle = tx_empty && !eng_busy;
  assign irq_o   = stat_q && mask_q;

  spi_eof_fifo #(.WIDTH(DATA_W + 1), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tx_rst),
    .push_i  (tx_wr),
    .data_i  ({mark_q, reg_wdata_i[DATA_W-1:0]}),
    .pop_i   (tx_pop),
    .data_o  (tx_head),
    .full_o  (tx_full),
    .empty_o (tx_empty),
    .count_o (tx_cnt)
  );

  spi_eof_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rx_rst),
    .push_i  (rx_push),
    .data_i  (eng_rx),
    .pop_i   (rx_rd),
    .data_o  (rx_head),
    .full_o  (rx_full),
    .empty_o (rx_empty),
    .count_o (rx_cnt)
  );

  spi_eof_engine #(.DW(DATA_W), .DIVW(DIV_W)) u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .abort_i      (tx_rst),
    .tx_en_i      (tx_en_q),
    .cpol_i       (mode_q[M_CPOL]),
    .cpha_i       (mode_q[M_CPHA]),
    .lsb_i        (mode_q[M_LSB]),
    .frame_en_i   (mode_q[M_FRAME]),
    .div_i        (div),
    .fifo_empty_i (tx_empty),
    .fifo_data_i  (tx_head),
    .fifo_pop_o   (tx_pop),
    .rx_push_o    (eng_push),
    .rx_data_o    (eng_rx),
    .busy_o       (eng_busy),
    .sck_o        (sck_o),
    .mosi_o       (mosi_o),
    .ss_n_o       (ss_n_o),
    .miso_i       (miso_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '0;
      div_reg_q <= '0;
      tx_en_q   <= 1'b0;
      rx_en_q   <= 1'b0;
      mark_q    <= 1'b0;
      ovf_q     <= 1'b0;
      ovr_q     <= 1'b0;
      stat_q    <= 1'b0;
      mask_q    <= 1'b0;
      tx_idle_q <= 1'b1;
    end else begin
      tx_idle_q <= tx_idle;
      if (reg_we_i && reg_addr_i == A_MODE) mode_q    <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == A_DIV)  div_reg_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == A_MASK) mask_q    <= reg_wdata_i[0];
      if (wr_cmd) begin
        if (reg_wdata_i[C_TX_OFF])      tx_en_q <= 1'b0;
        else if (reg_wdata_i[C_TX_ON])  tx_en_q <= 1'b1;
        if (reg_wdata_i[C_RX_OFF])      rx_en_q <= 1'b0;
        else if (reg_wdata_i[C_RX_ON])  rx_en_q <= 1'b1;
      end
      if (tx_rst)                                  mark_q <= 1'b0;
      else if (wr_cmd && reg_wdata_i[C_MARK])      mark_q <= 1'b1;
      else if (tx_wr)                              mark_q <= 1'b0;
      if (tx_rst)                   ovf_q <= 1'b0;
      else if (tx_wr && tx_full)    ovf_q <= 1'b1;
      if (rx_rst)                   ovr_q <= 1'b0;
      else if (rx_push && rx_full)  ovr_q <= 1'b1;
      if (tx_idle && !tx_idle_q)    stat_q <= 1'b1;
      else if (reg_we_i && reg_addr_i == A_STAT && reg_wdata_i[0]) stat_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_MODE:  reg_rdata_o = mode_q;
      A_DIV:   reg_rdata_o = div_reg_q;
      A_CMD:   reg_rdata_o = {29'b0, mark_q, rx_en_q, tx_en_q};
      A_TXD:   reg_rdata_o = '0;
      A_RXD:   reg_rdata_o = rx_empty ? '0 : {24'b0, rx_head};
      A_LEVEL: reg_rdata_o = {14'b0, ovr_q, ovf_q, 8'(tx_cnt), 8'(rx_cnt)};
      A_STAT:  reg_rdata_o = {31'b0, stat_q};
      A_MASK:  reg_rdata_o = {31'b0, mask_q};
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_eof_master_chk.sv
module spi_eof_master_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sck_i,
  input logic             ss_n_i,
  input logic             cpol_i,
  input logic             busy_i,
  input logic             tx_en_i,
  input logic             tx_rst_i,
  input logic             tx_pop_i,
  input logic             ovf_i,
  input logic             stat_i,
  input logic [CNT_W-1:0] tx_cnt_i,
  input logic [CNT_W-1:0] rx_cnt_i
);
  // R2
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (sck_i == cpol_i));

  // R7
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !tx_rst_i) |=> $stable(sck_i ^ cpol_i));

  // R6
  ss_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ss_n_i) |-> $past(tx_pop_i));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !tx_rst_i) |=> ovf_i);

  // R11
  stat_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_i) |-> $past((tx_cnt_i == '0) && !busy_i));

  // R12
  tx_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt_i <= CNT_W'(DEPTH));

  // R12
  rx_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt_i <= CNT_W'(DEPTH));
endmodule

bind spi_eof_master spi_eof_master_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sck_i    (sck_o),
  .ss_n_i   (ss_n_o),
  .cpol_i   (mode_q[13]),
  .busy_i   (eng_busy),
  .tx_en_i  (tx_en_q),
  .tx_rst_i (tx_rst),
  .tx_pop_i (tx_pop),
  .ovf_i    (ovf_q),
  .stat_i   (stat_q),
  .tx_cnt_i (tx_cnt),
  .rx_cnt_i (rx_cnt)
);

// File: tb/spi_eof_master_tb.sv
`timescale 1ns/1ps
module spi_eof_master_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, sck, mosi, ss_n;
  logic        cpol_v = 0, cpha_v = 0, lsb_v = 0;
  int          total = 0, bad = 0;

  always #2.5 clk = ~clk;

  spi_eof_master u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .sck_o(sck), .mosi_o(mosi), .miso_i(mosi), .ss_n_o(ss_n)
  );

  // slave model: samples mosi on the edge the mode calls for
  logic [7:0] cap_mem [64];
  int cap_n = 0, falls = 0, cyc = 0, last_cyc = 0, gmin = 0, gmax = 0, ss_gap = 0, bitc = 0;
  logic [7:0] sh = '0;
  logic prev_sck = 0, prev_ss = 1;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!ss_n) begin
      if (prev_ss) begin
        falls = falls + 1; gmin = 1 << 30; gmax = 0; last_cyc = -1; bitc = 0;
      end
      if (sck !== prev_sck) begin
        if (last_cyc >= 0) begin
          if (cyc - last_cyc < gmin) gmin = cyc - last_cyc;
          if (cyc - last_cyc > gmax) gmax = cyc - last_cyc;
        end
        last_cyc = cyc;
        if (cpha_v ? (prev_sck != cpol_v) : (prev_sck == cpol_v)) begin
          sh = lsb_v ? {mosi, sh[7:1]} : {sh[6:0], mosi};
          bitc = bitc + 1;
          if (bitc == 8) begin
            cap_mem[cap_n % 64] = sh; cap_n = cap_n + 1; bitc = 0;
          end
        end
      end
    end else if (!prev_ss) begin
      ss_gap = cyc - last_cyc;
    end
    prev_sck = sck;
    prev_ss  = ss_n;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_re = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int k = 0; k < 20000; k++) begin
      rd(3'd6, d);
      if (d[0]) return;
    end
    chk("R11 idle timeout", 0, 1);
  endtask

  task automatic set_mode(input logic p, input logic h, input logic l, input logic f);
    cpol_v = p; cpha_v = h; lsb_v = l;
    wr(3'd0, (32'(l) << 28) | (32'(p) << 13) | (32'(h) << 12) | (32'(f) << 11));
  endtask

  task automatic send(input logic [7:0] b);
    wr(3'd6, 32'h1);
    wr(3'd3, {24'b0, b});
    wait_idle();
  endtask

  // {cpol, cpha, lsb, byte}
  localparam logic [10:0] VEC [8] = '{
    {3'b000, 8'h1D}, {3'b010, 8'hB2}, {3'b100, 8'h47}, {3'b110, 8'hC8},
    {3'b001, 8'h5E}, {3'b011, 8'h93}, {3'b101, 8'h2F}, {3'b111, 8'hE4}
  };

  initial begin
    logic [31:0] d;
    int base, f0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ss_n", {31'b0, ss_n}, 1);
    chk("R1 sck", {31'b0, sck}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rst_ni = 1'b1;
    rd(3'd5, d); chk("R1 level", d, 0);
    rd(3'd2, d); chk("R1 cmd", d, 0);

    wr(3'd2, 32'h14);
    for (int i = 0; i < 8; i++) begin
      set_mode(VEC[i][10], VEC[i][9], VEC[i][8], 1'b0);
      @(negedge clk);
      chk("R2 idle sck", {31'b0, sck}, {31'b0, VEC[i][10]});
      base = cap_n;
      send(VEC[i][7:0]);
      chk("R2 R3 mosi byte", {24'b0, cap_mem[base % 64]}, {24'b0, VEC[i][7:0]});
      rd(3'd4, d); chk("R5 rx byte", d, {24'b0, VEC[i][7:0]});
    end

    // R4 divider split and readback; R6 framing
    wr(3'd1, 32'hA502_0000);
    rd(3'd1, d); chk("R4 readback", d, 32'hA502_0000);
    set_mode(0, 0, 0, 1);
    wr(3'd6, 32'h1);
    f0 = falls; base = cap_n;
    wr(3'd3, 32'h11); wr(3'd3, 32'h22); wr(3'd2, 32'h40); wr(3'd3, 32'h33);
    wait_idle();
    chk("R6 one frame", falls - f0, 1);
    chk("R6 byte3", {24'b0, cap_mem[(base + 2) % 64]}, 32'h33);
    chk("R6 ss released", {31'b0, ss_n}, 1);
    chk("R4 edge gap div2", gmin, 3);
    chk("R6 release gap", ss_gap, 3);
    rd(3'd5, d); chk("R5 rx count 3", d, 3);
    f0 = falls;
    send(8'h44);
    chk("R6 ss held untagged", {31'b0, ss_n}, 0);
    wr(3'd6, 32'h1); wr(3'd2, 32'h40); wr(3'd3, 32'h55); wait_idle();
    chk("R6 ss after tag", {31'b0, ss_n}, 1);
    chk("R6 single fall", falls - f0, 1);
    set_mode(0, 0, 0, 0);
    f0 = falls;
    wr(3'd6, 32'h1); wr(3'd3, 32'h66); wr(3'd3, 32'h77); wait_idle();
    chk("R6 unframed falls", falls - f0, 2);

    // R4 high byte of divider
    wr(3'd1, 32'h0000_0100);
    send(8'h5A);
    chk("R4 gap min 257", gmin, 257);
    chk("R4 gap max 257", gmax, 257);
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h1);
    rd(3'd5, d); chk("R10 rx flush", d, 0);

    // R7 transmitter disabled
    wr(3'd2, 32'h20);
    base = cap_n;
    wr(3'd3, 32'h6C);
    repeat (40) @(negedge clk);
    chk("R7 no select", {31'b0, ss_n}, 1);
    chk("R7 nothing shifted", cap_n - base, 0);
    rd(3'd5, d); chk("R7 queued", d, 32'h100);
    wr(3'd6, 32'h1); wr(3'd2, 32'h10); wait_idle();
    chk("R7 resumed", {24'b0, cap_mem[base % 64]}, 32'h6C);
    rd(3'd4, d); chk("R5 rx after resume", d, 32'h6C);

    // R8 receiver disabled
    wr(3'd2, 32'h08);
    send(8'h81);
    rd(3'd5, d); chk("R8 rx dropped", d, 0);
    wr(3'd2, 32'h04);

    // R9 overflow
    wr(3'd2, 32'h20);
    for (int i = 0; i < 17; i++) wr(3'd3, 32'(i));
    rd(3'd5, d); chk("R9 full and flag", d, 32'h1_1000);
    wr(3'd2, 32'h02);
    rd(3'd5, d); chk("R9 tx reset clears", d, 0);
    wr(3'd2, 32'h10);

    // R10 overrun
    wr(3'd6, 32'h1);
    for (int i = 0; i < 16; i++) wr(3'd3, 32'(8'hA0 + i));
    wait_idle();
    send(8'hFF);
    rd(3'd5, d); chk("R10 overrun", d, 32'h2_0010);
    rd(3'd4, d); chk("R5 oldest first", d, 32'hA0);
    wr(3'd2, 32'h01);
    rd(3'd5, d); chk("R10 rx reset clears", d, 0);

    // R11 status and mask
    wr(3'd7, 32'h0);
    send(8'h3E);
    chk("R11 masked irq", {31'b0, irq}, 0);
    wr(3'd7, 32'h1);
    @(negedge clk); chk("R11 irq on", {31'b0, irq}, 1);
    wr(3'd6, 32'h0);
    rd(3'd6, d); chk("R11 write0 keeps", d, 1);
    wr(3'd6, 32'h1);
    rd(3'd6, d); chk("R11 w1c", d, 0);
    chk("R11 irq off", {31'b0, irq}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule